// File: doc/BRIEF.md
# Timed Pin Unit

A single general-purpose pin that is tied to a free-running 64-bit nanosecond time base. In output direction the unit drives a scheduled edge onto the pin at the clock cycle in which the time base first reaches a programmed compare time. It can do this once, or repeat it, moving the compare time forward by a programmed interval after every edge. In input direction the pin is synchronised, and each edge of the selected polarity records the time base value and advances an event counter. The event count is copied at the same moment, so the stored time and the stored count always belong to the same event.

Software uses a 32-bit register port. Each 64-bit quantity takes two word addresses, with the low word at the lower address. Software sets up direction, edge polarity and repeat mode, and then sets the enable bit. The unit latches its working configuration only on the 0-to-1 transition of enable.

Top module: `timed_pin_unit`

## Requirements
- R1: After reset, pin_out and pin_oe are 0 and every register reads 0.
- R2: Byte offsets: control 0x00, compare 0x10 (low) / 0x14 (high), interval 0x18/0x1C, captured time 0x20/0x24, captured count 0x28/0x2C, live count 0x30/0x34. Control, compare and interval read back what was written. reg_rdata presents the addressed word one clock after the address is applied.
- R3: Control bits: bit 0 enable, bit 1 direction (1 = input, 0 = output), bits 3:2 edge (0 = rising, 1 = falling, 2 = both), bit 4 repeat. Direction, edge and repeat take effect only from the value written when enable goes from 0 to 1. Later writes that keep enable at 1 do not change the running behaviour.
- R4: In output direction with repeat clear, pin_out updates at the clock edge that ends the first cycle in which time_ns >= compare. A rising setting drives 1, falling drives 0, and both inverts the pin. No further edge follows.
- R5: With repeat set, each fire adds the interval to the compare value. The new value reads back at 0x10/0x14, and the pin fires again when time_ns reaches it.
- R6: pin_oe is 1 exactly while the unit is enabled in output direction.
- R7: pin_in passes through two synchronising flops. A captured time equals the time_ns value present in the second cycle after the first clock edge that samples the changed pin level.
- R8: Every qualifying input edge adds one to the live count. In the same cycle it loads the captured count with the new live count and loads the captured time.
- R9: A 0-to-1 transition of enable clears the live count and leaves the captured time and captured count unchanged.
- R10: While disabled, no output edge fires, pin_out holds its level, and input edges change neither the counts nor the captured time.
- R11: Writes to the captured-time, captured-count and live-count offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_ns | input | 64 | Free-running time base in nanoseconds |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | 1 | Asynchronous pin level in input direction |
| pin_out | output | 1 | Driven pin level in output direction |
| pin_oe | output | 1 | Output enable for the pin |

## Verification
Output scheduling is tested with rising and falling one-shot edges and with a toggling repeat train. Compare times and intervals are random and fall off the time-step grid, which separates "at or after compare" from "exactly at compare" and confirms that the interval is added to the compare value, not to the time of the fire. Input capture is tested with random toggle trains under each of the three edge settings: rising-only and falling-only patterns show that polarity is honoured, and the both-edges pattern shows that every change is counted. Directed cases cover a control change made while enabled, disabled stimulus, re-enabling, and writes to read-only offsets.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int REG_AW = 6;
  localparam int WORD_W = 32;

  localparam logic [REG_AW-1:0] OFF_CTRL    = 6'h00;
  localparam logic [REG_AW-1:0] OFF_CMP_LO  = 6'h10;
  localparam logic [REG_AW-1:0] OFF_CMP_HI  = 6'h14;
  localparam logic [REG_AW-1:0] OFF_IVL_LO  = 6'h18;
  localparam logic [REG_AW-1:0] OFF_IVL_HI  = 6'h1C;
  localparam logic [REG_AW-1:0] OFF_CAPT_LO = 6'h20;
  localparam logic [REG_AW-1:0] OFF_CAPT_HI = 6'h24;
  localparam logic [REG_AW-1:0] OFF_CAPC_LO = 6'h28;
  localparam logic [REG_AW-1:0] OFF_CAPC_HI = 6'h2C;
  localparam logic [REG_AW-1:0] OFF_LIVE_LO = 6'h30;
  localparam logic [REG_AW-1:0] OFF_LIVE_HI = 6'h34;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_RSVD = 2'd3
  } edge_sel_e;

  // packed order gives: [4] repeat, [3:2] edge, [1] input dir, [0] enable
  typedef struct packed {
    logic      rpt;
    edge_sel_e edge_sel;
    logic      dir_in;
    logic      en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tp_sync.sv
module tp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tp_sched.sv
module tp_sched
  import tp_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_ns,
  input  logic              arm,
  input  logic              run,
  input  logic              rpt,
  input  edge_sel_e         edge_sel,
  input  logic              cmp_wr_lo,
  input  logic              cmp_wr_hi,
  input  logic              ivl_wr_lo,
  input  logic              ivl_wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [TIME_W-1:0] cmp_val,
  output logic [TIME_W-1:0] ivl_val,
  output logic              pin_q,
  output logic              fire
);
  localparam int HI_W = TIME_W - WORD_W;

  logic [TIME_W-1:0] cmp_q;
  logic [TIME_W-1:0] ivl_q;
  logic              armed_q;
  logic              pin_r;

  assign fire = run & armed_q & (time_ns >= cmp_q);

  always_ff @(posedge clk) begin
    if (rst)                armed_q <= 1'b0;
    else if (arm)           armed_q <= 1'b1;
    else if (fire && !rpt)  armed_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
    end else if (cmp_wr_lo) begin
      cmp_q[WORD_W-1:0] <= wdata;
    end else if (cmp_wr_hi) begin
      cmp_q[TIME_W-1:WORD_W] <= wdata[HI_W-1:0];
    end else if (fire && rpt) begin
      cmp_q <= cmp_q + ivl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_q <= '0;
    end else if (ivl_wr_lo) begin
      ivl_q[WORD_W-1:0] <= wdata;
    end else if (ivl_wr_hi) begin
      ivl_q[TIME_W-1:WORD_W] <= wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_r <= 1'b0;
    end else if (fire) begin
      case (edge_sel)
        EDGE_RISE: pin_r <= 1'b1;
        EDGE_FALL: pin_r <= 1'b0;
        default:   pin_r <= ~pin_r;
      endcase
    end
  end

  assign cmp_val = cmp_q;
  assign ivl_val = ivl_q;
  assign pin_q   = pin_r;
endmodule

// File: rtl/tp_stamp.sv
module tp_stamp
  import tp_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_ns,
  input  logic              clr,
  input  logic              run,
  input  edge_sel_e         edge_sel,
  input  logic              rise,
  input  logic              fall,
  output logic [TIME_W-1:0] capt_time,
  output logic [CNT_W-1:0]  capt_cnt,
  output logic [CNT_W-1:0]  live_cnt,
  output logic              cap_stb
);
  logic [TIME_W-1:0] capt_time_q;
  logic [CNT_W-1:0]  capt_cnt_q;
  logic [CNT_W-1:0]  live_q;
  logic              qual;

  always_comb begin
    case (edge_sel)
      EDGE_RISE: qual = rise;
      EDGE_FALL: qual = fall;
      default:   qual = rise | fall;
    endcase
  end

  assign cap_stb = run & qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q      <= '0;
      capt_cnt_q  <= '0;
      capt_time_q <= '0;
    end else if (clr) begin
      live_q <= '0;
    end else if (cap_stb) begin
      live_q      <= live_q + 1'b1;
      capt_cnt_q  <= live_q + 1'b1;
      capt_time_q <= time_ns;
    end
  end

  assign capt_time = capt_time_q;
  assign capt_cnt  = capt_cnt_q;
  assign live_cnt  = live_q;
endmodule

// File: rtl/timed_pin_unit.sv
module timed_pin_unit
  import tp_pkg::*;
#(
  parameter int TIME_W      = 64,
  parameter int CNT_W       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_ns,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe
);
  localparam int PAD_W = WORD_W - CTRL_W;

  ctrl_t     ctrl_q;
  ctrl_t     wr_ctrl_val;
  logic      act_en;
  logic      act_dir;
  logic      act_rpt;
  edge_sel_e act_edge;

  logic wr_ctrl, en_rise, en_fall;
  logic cmp_wr_lo, cmp_wr_hi, ivl_wr_lo, ivl_wr_hi, cmp_wr;
  logic run_out, run_in;

  logic [TIME_W-1:0] cmp_w, ivl_w, capt_time_w;
  logic [CNT_W-1:0]  capt_cnt_w, live_cnt_w;
  logic              fire_w, cap_stb_w, pin_q_w;
  logic              rise_w, fall_w;
  logic [WORD_W-1:0] rd_next;

  assign wr_ctrl     = reg_wr && (reg_addr == OFF_CTRL);
  assign wr_ctrl_val = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign en_rise     = wr_ctrl && wr_ctrl_val.en && !ctrl_q.en;
  assign en_fall     = wr_ctrl && !wr_ctrl_val.en;
  assign cmp_wr_lo   = reg_wr && (reg_addr == OFF_CMP_LO);
  assign cmp_wr_hi   = reg_wr && (reg_addr == OFF_CMP_HI);
  assign ivl_wr_lo   = reg_wr && (reg_addr == OFF_IVL_LO);
  assign ivl_wr_hi   = reg_wr && (reg_addr == OFF_IVL_HI);
  assign cmp_wr      = cmp_wr_lo | cmp_wr_hi;

  // control word as written, for readback
  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_ctrl_val;
  end

  // working configuration, sampled only when enable rises
  always_ff @(posedge clk) begin
    if (rst) begin
      act_en   <= 1'b0;
      act_dir  <= 1'b0;
      act_rpt  <= 1'b0;
      act_edge <= EDGE_RISE;
    end else if (en_rise) begin
      act_en   <= 1'b1;
      act_dir  <= wr_ctrl_val.dir_in;
      act_rpt  <= wr_ctrl_val.rpt;
      act_edge <= wr_ctrl_val.edge_sel;
    end else if (en_fall) begin
      act_en   <= 1'b0;
    end
  end

  assign run_out = act_en & ~act_dir;
  assign run_in  = act_en & act_dir;

  tp_sched #(.TIME_W(TIME_W)) u_sched (
    .clk       (clk),
    .rst       (rst),
    .time_ns   (time_ns),
    .arm       (en_rise),
    .run       (run_out),
    .rpt       (act_rpt),
    .edge_sel  (act_edge),
    .cmp_wr_lo (cmp_wr_lo),
    .cmp_wr_hi (cmp_wr_hi),
    .ivl_wr_lo (ivl_wr_lo),
    .ivl_wr_hi (ivl_wr_hi),
    .wdata     (reg_wdata),
    .cmp_val   (cmp_w),
    .ivl_val   (ivl_w),
    .pin_q     (pin_q_w),
    .fire      (fire_w)
  );

  tp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .rise (rise_w),
    .fall (fall_w)
  );

  tp_stamp #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_stamp (
    .clk       (clk),
    .rst       (rst),
    .time_ns   (time_ns),
    .clr       (en_rise),
    .run       (run_in),
    .edge_sel  (act_edge),
    .rise      (rise_w),
    .fall      (fall_w),
    .capt_time (capt_time_w),
    .capt_cnt  (capt_cnt_w),
    .live_cnt  (live_cnt_w),
    .cap_stb   (cap_stb_w)
  );

  function automatic logic [WORD_W-1:0] word_of(input logic [63:0] v, input logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

  always_comb begin
    case (reg_addr)
      OFF_CTRL:    rd_next = {{PAD_W{1'b0}}, ctrl_q};
      OFF_CMP_LO:  rd_next = word_of(64'(cmp_w), 1'b0);
      OFF_CMP_HI:  rd_next = word_of(64'(cmp_w), 1'b1);
      OFF_IVL_LO:  rd_next = word_of(64'(ivl_w), 1'b0);
      OFF_IVL_HI:  rd_next = word_of(64'(ivl_w), 1'b1);
      OFF_CAPT_LO: rd_next = word_of(64'(capt_time_w), 1'b0);
      OFF_CAPT_HI: rd_next = word_of(64'(capt_time_w), 1'b1);
      OFF_CAPC_LO: rd_next = word_of(64'(capt_cnt_w), 1'b0);
      OFF_CAPC_HI: rd_next = word_of(64'(capt_cnt_w), 1'b1);
      OFF_LIVE_LO: rd_next = word_of(64'(live_cnt_w), 1'b0);
      OFF_LIVE_HI: rd_next = word_of(64'(live_cnt_w), 1'b1);
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assign pin_out = pin_q_w;
  assign pin_oe  = run_out;
endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
  parameter int TIME_W = 64,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              act_en,
  input logic              act_dir,
  input logic              act_rpt,
  input logic              en_rise,
  input logic              cmp_wr,
  input logic              fire,
  input logic              cap_stb,
  input logic              pin_out,
  input logic [TIME_W-1:0] cmp_val,
  input logic [TIME_W-1:0] ivl_val,
  input logic [CNT_W-1:0]  live_cnt,
  input logic [CNT_W-1:0]  capt_cnt
);
  AST_PIN_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(act_en && !act_dir) |=> $stable(pin_out)); // R10

  AST_ONESHOT_ONCE: assert property (@(posedge clk) disable iff (rst)
    (fire && !act_rpt && !en_rise) |=> !fire); // R4

  AST_PERIOD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (fire && act_rpt && !cmp_wr) |=> (cmp_val == $past(cmp_val) + $past(ivl_val))); // R5

  AST_CAPT_CNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> (capt_cnt == live_cnt)); // R8

  AST_LIVE_STEP: assert property (@(posedge clk) disable iff (rst)
    !en_rise |=> (live_cnt == $past(live_cnt) || live_cnt == $past(live_cnt) + 1'b1)); // R8

  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> (live_cnt == '0)); // R9
endmodule

bind timed_pin_unit tp_chk #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_tp_chk (
  .clk      (clk),
  .rst      (rst),
  .act_en   (act_en),
  .act_dir  (act_dir),
  .act_rpt  (act_rpt),
  .en_rise  (en_rise),
  .cmp_wr   (cmp_wr),
  .fire     (fire_w),
  .cap_stb  (cap_stb_w),
  .pin_out  (pin_out),
  .cmp_val  (cmp_w),
  .ivl_val  (ivl_w),
  .live_cnt (live_cnt_w),
  .capt_cnt (capt_cnt_w)
);

// File: tb/test_timed_pin_unit.sv
module test_timed_pin_unit;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 5;

  localparam logic [5:0] A_CTRL = 6'h00, A_CMP = 6'h10, A_IVL = 6'h18,
                         A_CAPT = 6'h20, A_CAPC = 6'h28, A_LIVE = 6'h30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] tb_time = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [63:0] chg_t [64];
  int          n_chg = 0;
  logic        prev_pin = 1'b0;

  logic [63:0] m_capt = '0;
  logic [63:0] m_capc = '0;

  timed_pin_unit i_timed_pin_unit (
    .clk(clk), .rst(rst), .time_ns(tb_time),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tb_time <= tb_time + STEP;

  // output edge monitor: a change seen now was made at the last posedge,
  // which compared the time value one step older than the current one
  always @(negedge clk) begin
    if (!rst) begin
      if (pin_out !== prev_pin) begin
        if (n_chg < 64) chg_t[n_chg] = tb_time - STEP;
        n_chg++;
      end
      prev_pin = pin_out;
    end
  end

  function automatic logic [63:0] snap(input logic [63:0] x);
    return ((x + STEP - 1) / STEP) * STEP;
  endfunction

  function automatic logic [31:0] cw(input bit en, input bit dir, input logic [1:0] e, input bit rp);
    return {27'd0, rp, e, dir, en};
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wr64(input logic [5:0] a, input logic [63:0] v);
    wr(a, v[31:0]);
    wr(a + 6'd4, v[63:32]);
  endtask

  task automatic rd64(input logic [5:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 6'd4, hi);
    v = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_pin(input int gap, input logic [1:0] e, input logic [63:0] base_cnt,
                            inout logic [63:0] cnt);
    idle(gap);
    pin_in = ~pin_in;
    if (e == 2'd2 || (e == 2'd0 && pin_in) || (e == 2'd1 && !pin_in)) begin
      cnt++;
      m_capt = tb_time + 2 * STEP;
      m_capc = base_cnt + cnt;
    end
  endtask

  task automatic oneshot(input logic [1:0] e, input logic lvl, input string tag);
    logic [63:0] c;
    int k0;
    wr(A_CTRL, 32'd0);
    c = tb_time + 64'd60 + 64'($urandom % 37);
    wr64(A_CMP, c);
    wr(A_CTRL, cw(0, 0, e, 0));
    k0 = n_chg;
    wr(A_CTRL, cw(1, 0, e, 0));
    chk("R6 oe while output enabled", 64'(pin_oe), 64'd1);
    while (tb_time < c + 20 * STEP) @(negedge clk);
    chk({"R4 ", tag, " edge count"}, 64'(n_chg - k0), 64'd1);
    chk({"R4 ", tag, " edge time"}, chg_t[k0], snap(c));
    chk({"R4 ", tag, " level"}, 64'(pin_out), 64'(lvl));
    idle(12);
    chk({"R4 ", tag, " no refire"}, 64'(n_chg - k0), 64'd1);
  endtask

  task automatic periodic();
    logic [63:0] c, iv, v;
    int k0, nf, guard;
    wr(A_CTRL, 32'd0);
    c  = tb_time + 64'd80 + 64'($urandom % 23);
    iv = 64'd25 + 64'($urandom % 40);
    wr64(A_CMP, c);
    wr64(A_IVL, iv);
    wr(A_CTRL, cw(0, 0, 2'd2, 1));
    k0 = n_chg;
    wr(A_CTRL, cw(1, 0, 2'd2, 1));
    guard = 0;
    while (n_chg - k0 < 4 && guard < 500) begin @(negedge clk); guard++; end
    wr(A_CTRL, 32'd0);
    idle(2);
    nf = n_chg - k0;
    for (int k = 0; k < 4; k++)
      chk("R5 repeat edge time", chg_t[k0 + k], snap(c + 64'(k) * iv));
    rd64(A_CMP, v);
    chk("R5 compare advanced", v, c + 64'(nf) * iv);
    chk("R6 oe after disable", 64'(pin_oe), 64'd0);
    while (tb_time < v + 10 * STEP) @(negedge clk);
    chk("R10 no fire while disabled", 64'(n_chg - k0), 64'(nf));
  endtask

  task automatic in_pattern(input logic [1:0] e, input int m);
    logic [63:0] cnt, v;
    wr(A_CTRL, cw(0, 1, e, 0));
    wr(A_CTRL, cw(1, 1, e, 0));
    cnt = '0;
    for (int i = 0; i < m; i++) toggle_pin(3 + int'($urandom % 6), e, 64'd0, cnt);
    idle(5);
    rd64(A_CAPT, v);  chk("R7 captured time", v, m_capt);
    rd64(A_CAPC, v);  chk("R8 captured count", v, m_capc);
    rd64(A_LIVE, v);  chk("R8 live count", v, cnt);
  endtask

  initial begin
    logic [63:0] v, v2;
    logic [31:0] w;
    void'($urandom(32'd1234));
    idle(3);
    rst = 1'b0;
    idle(1);

    chk("R1 pin_out reset", 64'(pin_out), 64'd0);
    chk("R1 pin_oe reset", 64'(pin_oe), 64'd0);
    rd(A_CTRL, w);   chk("R1 ctrl reset", 64'(w), 64'd0);
    rd64(A_CMP, v);  chk("R1 compare reset", v, 64'd0);
    rd64(A_LIVE, v); chk("R1 live reset", v, 64'd0);

    wr64(A_IVL, 64'h1234_5678_9ABC_DEF0);
    rd64(A_IVL, v);  chk("R2 interval readback", v, 64'h1234_5678_9ABC_DEF0);
    wr(A_CTRL, cw(0, 1, 2'd2, 1));
    rd(A_CTRL, w);   chk("R2 ctrl readback", 64'(w), 64'(cw(0, 1, 2'd2, 1)));

    oneshot(2'd0, 1'b1, "rise");
    oneshot(2'd1, 1'b0, "fall");
    periodic();

    // R3: configuration changed while enabled is not taken
    wr(A_CTRL, 32'd0);
    pin_in = 1'b0;
    idle(4);
    wr(A_CTRL, cw(0, 1, 2'd1, 0));
    wr(A_CTRL, cw(1, 1, 2'd1, 0));
    wr(A_CTRL, cw(1, 1, 2'd0, 0));
    idle(2);
    pin_in = 1'b1;
    idle(6);
    rd64(A_LIVE, v); chk("R3 rising ignored under latched falling", v, 64'd0);
    idle(1);
    pin_in = 1'b0;
    m_capt = tb_time + 2 * STEP;
    m_capc = 64'd1;
    idle(6);
    rd64(A_LIVE, v); chk("R3 falling counted", v, 64'd1);
    rd64(A_CAPT, v); chk("R7 captured time directed", v, m_capt);

    // random input patterns under each edge setting
    for (int r = 0; r < 2; r++)
      for (int e = 0; e < 3; e++)
        in_pattern(2'(e), 4 + int'($urandom % 7));

    // R9: re-enable clears live, keeps captures
    wr(A_CTRL, 32'd0);
    wr(A_CTRL, cw(1, 1, 2'd2, 0));
    rd64(A_LIVE, v); chk("R9 live cleared on enable", v, 64'd0);
    rd64(A_CAPC, v); chk("R9 captured count kept", v, m_capc);
    rd64(A_CAPT, v); chk("R9 captured time kept", v, m_capt);

    // R10: disabled input ignored
    wr(A_CTRL, 32'd0);
    idle(4); pin_in = ~pin_in;
    idle(4); pin_in = ~pin_in;
    idle(6);
    rd64(A_LIVE, v); chk("R10 live unchanged while disabled", v, 64'd0);
    rd64(A_CAPT, v); chk("R10 capture unchanged while disabled", v, m_capt);

    // R11: read-only offsets ignore writes
    rd64(A_CAPT, v2);
    wr(A_CAPT, 32'hFFFF_FFFF); wr(A_CAPT + 6'd4, 32'hFFFF_FFFF);
    wr(A_CAPC, 32'hFFFF_FFFF); wr(A_LIVE, 32'hFFFF_FFFF);
    rd64(A_CAPT, v); chk("R11 captured time after write", v, v2);
    rd64(A_CAPC, v); chk("R11 captured count after write", v, m_capc);
    rd64(A_LIVE, v); chk("R11 live after write", v, 64'd0);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule